// File: doc/BRIEF.md
# Multi-Rail Regulator Startup Sequencer

This block runs the digital power-up sequence of a multiphase regulator controller with two rails of up to three phases each. After reset, a fixed configuration window runs while every PWM output is released. At the end of that window the block captures the boot target code, the slew selection and the per-phase population flags. A phase whose sense input was pulled to the supply counts as absent and is parked low. The first phase of rail 0 stays enabled whatever its flag says.

When enable is high, every populated phase sits in the mid (diode-emulation) level for one full cycle before the driver enable goes high. The block then waits for the driver-ready line and ramps a digital DAC target from zero up to the captured boot code, one LSB at a time, at the soft-start rate. The soft-start rate is half the selected fast slew rate. Each populated phase stays at mid until the modulator produces its first pulse after the ramp has begun. From then on the phase follows its pulse. Dropping enable returns every populated phase to mid and restarts the sequence.

Top module: `ssq_top`

## Requirements
- R1: For the first CFG_CYCLES clock cycles after reset, every PWM request is high-impedance (code 2'b11), drvEn is low and dacCode is zero.
- R2: The population flags are captured on the last configuration cycle. Afterwards a phase whose flag was 1 is held LOW (2'b00) and a populated phase rests at MID (2'b10). Phase i uses pwmReq bits [2i+1:2i] and phaseAbsent bit i, with phase i = rail*3 + k. Phase 0 is always populated.
- R3: A phase that is absent, including every phase of a rail whose flags were all 1, stays LOW at all times after configuration and ignores its pulse input.
- R4: After enable rises, drvEn stays low for one cycle in which all populated phases are MID. drvEn rises on the following clock edge.
- R5: While drvReady is low after drvEn has been asserted, dacCode stays 0, ssDone stays 0 and populated phases stay MID.
- R6: Once drvReady is high, dacCode rises by exactly 1 every 2*FAST_PER_0 cycles (slew 0) or every 2*FAST_PER_1 cycles (slew 1). It stops at the boot code. ssDone rises boot*period+2 clock edges after drvReady is seen high.
- R7: A populated phase leaves MID only on a clock edge where its pulse input is high once the ramp has begun. It then shows HIGH (2'b01) or LOW on each edge according to the pulse input sampled there. Pulses before the ramp are ignored.
- R8: When enable goes low after configuration, on the next edge populated phases go to MID, drvEn and ssDone go low and dacCode goes to 0.
- R9: The boot code and slew selection are captured once during configuration. Later changes on those inputs have no effect on the ramp.
- R10: With a boot code of zero, ssDone rises two edges after drvReady is seen high, dacCode stays 0 and populated phases remain MID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Regulator enable |
| drvReady | input | 1 | Driver-ready line, low holds off the ramp |
| phaseAbsent | input | 6 | Per-phase flag, 1 = sense input pulled up (phase absent) |
| bootCode | input | 8 | Boot target code, captured in configuration |
| slewSel | input | 1 | Fast slew selection, captured in configuration |
| pwmPulse | input | 6 | Per-phase modulator pulse |
| pwmReq | output | 12 | Per-phase level request, 2 bits each |
| drvEn | output | 1 | Driver enable |
| dacCode | output | 8 | Soft-start DAC target |
| ssDone | output | 1 | Soft-start complete |

## Verification
The assertions assume that reset is held long enough to clear every register. They also assume the configuration inputs are settled before the configuration window closes. Pulse and ready inputs may change at any time after that. The stimulus changes inputs only on falling edges. It applies bootCode, slewSel and phaseAbsent before reset is released, then deliberately inverts them once configuration has closed. It keeps random boot codes small enough that each ramp ends well within the run.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [1:0] {
    PWM_LOW  = 2'b00,
    PWM_HIGH = 2'b01,
    PWM_MID  = 2'b10,
    PWM_HIZ  = 2'b11
  } pwmLevel_e;

  typedef enum logic [2:0] {
    ST_CFG,
    ST_IDLE,
    ST_MIDSET,
    ST_DRVON,
    ST_RAMP,
    ST_DONE
  } seqState_e;

  typedef struct packed {
    logic cfgPhase;
    logic latchCfg;
    logic clear;
    logic rampRun;
    logic pulseArm;
  } seqStrobe_t;

endpackage

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
#(
  parameter int CFG_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       drvReady,
  input  logic       atTarget,
  output seqStrobe_t strb,
  output logic       drvEn,
  output logic       ssDone
);

  localparam int CW = (CFG_CYCLES > 1) ? $clog2(CFG_CYCLES) : 1;
  localparam logic [CW-1:0] CFG_LAST = CW'(CFG_CYCLES - 1);

  seqState_e state, stateNext;
  logic [CW-1:0] cfgCnt;
  logic cfgLast;

  assign cfgLast = (state == ST_CFG) && (cfgCnt == CFG_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_CFG;
      cfgCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_CFG && !cfgLast) cfgCnt <= cfgCnt + 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_CFG:    if (cfgLast) stateNext = ST_IDLE;
      ST_IDLE:   if (enable) stateNext = ST_MIDSET;
      ST_MIDSET: stateNext = enable ? ST_DRVON : ST_IDLE;
      ST_DRVON:  if (!enable) stateNext = ST_IDLE;
                 else if (drvReady) stateNext = ST_RAMP;
      ST_RAMP:   if (!enable) stateNext = ST_IDLE;
                 else if (atTarget) stateNext = ST_DONE;
      ST_DONE:   if (!enable) stateNext = ST_IDLE;
      default:   stateNext = ST_CFG;
    endcase
  end

  logic running;
  assign running = (state == ST_RAMP) || (state == ST_DONE);

  always_comb begin
    strb.cfgPhase = (state == ST_CFG);
    strb.latchCfg = cfgLast;
    strb.rampRun  = (state == ST_RAMP);
    strb.pulseArm = running;
    strb.clear    = (state != ST_CFG) && (!enable || !running);
  end

  assign drvEn  = (state == ST_DRVON) || running;
  assign ssDone = (state == ST_DONE);

  AST_DRV_AFTER_MID: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEn) |-> $past(state) == ST_MIDSET); // R4

  AST_NO_RAMP_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRVON && !drvReady) |=> state != ST_RAMP); // R5

  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAMP && atTarget && enable) |=> ssDone); // R10

  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_CFG && !enable) |=> (!drvEn && !ssDone)); // R8

endmodule

// File: rtl/ssq_datapath.sv
module ssq_datapath
  import ssq_pkg::*;
#(
  parameter int NRAIL       = 2,
  parameter int PH_PER_RAIL = 3,
  parameter int DAC_W       = 8,
  parameter int FAST_PER_0  = 2,
  parameter int FAST_PER_1  = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  seqStrobe_t                     strb,
  input  logic [NRAIL*PH_PER_RAIL-1:0]   phaseAbsent,
  input  logic [DAC_W-1:0]               bootCode,
  input  logic                           slewSel,
  input  logic [NRAIL*PH_PER_RAIL-1:0]   pwmPulse,
  output logic [2*NRAIL*PH_PER_RAIL-1:0] pwmReq,
  output logic [DAC_W-1:0]               dacCode,
  output logic                           atTarget
);

  localparam int NPH      = NRAIL * PH_PER_RAIL;
  localparam int SS_PER_0 = 2 * FAST_PER_0;
  localparam int SS_PER_1 = 2 * FAST_PER_1;
  localparam int PER_MAX  = (SS_PER_0 > SS_PER_1) ? SS_PER_0 : SS_PER_1;
  localparam int DIV_W    = $clog2(PER_MAX + 1);

  logic [DAC_W-1:0] bootQ;
  logic             slewQ;
  logic [NPH-1:0]   phaseOnQ;
  logic [NPH-1:0]   phaseOnRaw;

  always_comb begin
    phaseOnRaw    = ~phaseAbsent;
    phaseOnRaw[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootQ    <= '0;
      slewQ    <= 1'b0;
      phaseOnQ <= '0;
    end else if (strb.latchCfg) begin
      bootQ    <= bootCode;
      slewQ    <= slewSel;
      phaseOnQ <= phaseOnRaw;
    end
  end

  // Soft-start step divider and DAC counter
  logic [DIV_W-1:0] stepPer;
  logic [DIV_W-1:0] divQ;
  logic [DAC_W-1:0] dacQ;

  assign stepPer  = slewQ ? DIV_W'(SS_PER_1) : DIV_W'(SS_PER_0);
  assign atTarget = (dacQ == bootQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ <= '0;
      dacQ <= '0;
    end else if (strb.clear) begin
      divQ <= '0;
      dacQ <= '0;
    end else if (strb.rampRun && !atTarget) begin
      if (divQ == stepPer - 1'b1) begin
        divQ <= '0;
        dacQ <= dacQ + 1'b1;
      end else begin
        divQ <= divQ + 1'b1;
      end
    end
  end

  assign dacCode = dacQ;

  // Per-phase level request
  for (genvar i = 0; i < NPH; i++) begin : g_phase
    pwmLevel_e pwmQ;
    logic      activeQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeQ <= 1'b0;
        pwmQ    <= PWM_HIZ;
      end else if (strb.cfgPhase) begin
        activeQ <= 1'b0;
        pwmQ    <= PWM_HIZ;
      end else if (!phaseOnQ[i]) begin
        activeQ <= 1'b0;
        pwmQ    <= PWM_LOW;
      end else if (strb.clear) begin
        activeQ <= 1'b0;
        pwmQ    <= PWM_MID;
      end else if (activeQ || (strb.pulseArm && pwmPulse[i])) begin
        activeQ <= 1'b1;
        pwmQ    <= pwmPulse[i] ? PWM_HIGH : PWM_LOW;
      end else begin
        pwmQ    <= PWM_MID;
      end
    end

    assign pwmReq[2*i +: 2] = pwmQ;

    AST_CFG_HIZ: assert property (@(posedge clk) disable iff (!rstN)
      strb.cfgPhase |-> pwmQ == PWM_HIZ); // R1

    AST_ABSENT_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.cfgPhase && !phaseOnQ[i]) |=> pwmQ == PWM_LOW); // R3

    AST_MID_UNTIL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      (pwmQ == PWM_MID && !pwmPulse[i]) |=> pwmQ != PWM_HIGH); // R7

    AST_CLEAR_MID: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clear && phaseOnQ[i]) |=> pwmQ == PWM_MID); // R8
  end

  AST_DAC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dacQ != $past(dacQ)) |-> ((dacQ == $past(dacQ) + 1'b1) || (dacQ == '0))); // R6

  AST_DAC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    dacQ <= bootQ); // R6

  AST_BOOT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgPhase |=> ($stable(bootQ) && $stable(slewQ))); // R9

endmodule

// File: rtl/ssq_top.sv
module ssq_top
  import ssq_pkg::*;
#(
  parameter int NRAIL       = 2,
  parameter int PH_PER_RAIL = 3,
  parameter int DAC_W       = 8,
  parameter int CFG_CYCLES  = 8,
  parameter int FAST_PER_0  = 2,
  parameter int FAST_PER_1  = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           enable,
  input  logic                           drvReady,
  input  logic [NRAIL*PH_PER_RAIL-1:0]   phaseAbsent,
  input  logic [DAC_W-1:0]               bootCode,
  input  logic                           slewSel,
  input  logic [NRAIL*PH_PER_RAIL-1:0]   pwmPulse,
  output logic [2*NRAIL*PH_PER_RAIL-1:0] pwmReq,
  output logic                           drvEn,
  output logic [DAC_W-1:0]               dacCode,
  output logic                           ssDone
);

  seqStrobe_t strb;
  logic       atTarget;

  ssq_ctrl #(
    .CFG_CYCLES(CFG_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .drvReady (drvReady),
    .atTarget (atTarget),
    .strb     (strb),
    .drvEn    (drvEn),
    .ssDone   (ssDone)
  );

  ssq_datapath #(
    .NRAIL       (NRAIL),
    .PH_PER_RAIL (PH_PER_RAIL),
    .DAC_W       (DAC_W),
    .FAST_PER_0  (FAST_PER_0),
    .FAST_PER_1  (FAST_PER_1)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .phaseAbsent (phaseAbsent),
    .bootCode    (bootCode),
    .slewSel     (slewSel),
    .pwmPulse    (pwmPulse),
    .pwmReq      (pwmReq),
    .dacCode     (dacCode),
    .atTarget    (atTarget)
  );

endmodule

// File: tb/tb_ssq_top.sv
module tb_ssq_top;

  localparam int NPH  = 6;
  localparam int CFGN = 8;
  localparam int F0   = 2;
  localparam int F1   = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             drvReady = 1'b0;
  logic [NPH-1:0]   phaseAbsent = '0;
  logic [7:0]       bootCode = '0;
  logic             slewSel = 1'b0;
  logic [NPH-1:0]   pwmPulse = '0;
  logic [2*NPH-1:0] pwmReq;
  logic             drvEn;
  logic [7:0]       dacCode;
  logic             ssDone;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ssq_top dut (
    .clk(clk), .rstN(rstN), .enable(enable), .drvReady(drvReady),
    .phaseAbsent(phaseAbsent), .bootCode(bootCode), .slewSel(slewSel),
    .pwmPulse(pwmPulse), .pwmReq(pwmReq), .drvEn(drvEn),
    .dacCode(dacCode), .ssDone(ssDone)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NPH-1:0] onMask(input logic [NPH-1:0] absent);
    logic [NPH-1:0] m;
    m = ~absent;
    m[0] = 1'b1;
    return m;
  endfunction

  function automatic logic [2*NPH-1:0] restPattern(input logic [NPH-1:0] on);
    logic [2*NPH-1:0] p;
    for (int i = 0; i < NPH; i++) p[2*i +: 2] = on[i] ? 2'b10 : 2'b00;
    return p;
  endfunction

  function automatic logic [2*NPH-1:0] livePattern(input logic [NPH-1:0] on,
      input logic [NPH-1:0] act, input logic [NPH-1:0] pul);
    logic [2*NPH-1:0] p;
    for (int i = 0; i < NPH; i++) begin
      if (!on[i])      p[2*i +: 2] = 2'b00;
      else if (act[i]) p[2*i +: 2] = pul[i] ? 2'b01 : 2'b00;
      else             p[2*i +: 2] = 2'b10;
    end
    return p;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_trial(input logic [7:0] boot, input logic slew, input logic [NPH-1:0] absent);
    logic [NPH-1:0] on;
    logic [NPH-1:0] act;
    logic [NPH-1:0] pul;
    int per;
    int expGap;
    int n;
    on  = onMask(absent);
    per = 2 * (slew ? F1 : F0);
    expGap = boot * per + 2;

    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; drvReady = 1'b0; pwmPulse = '0;
    bootCode = boot; slewSel = slew; phaseAbsent = absent;
    repeat (3) step();
    rstN = 1'b1;
    repeat (CFGN) step();
    chk(pwmReq == '1, "R1 hiz during config", pwmReq, '1);
    chk(!drvEn && dacCode == 0, "R1 drvEn/dac during config", {drvEn, dacCode}, 0);

    // Scramble config inputs after capture
    bootCode = ~boot; slewSel = ~slew; phaseAbsent = ~absent;
    step();
    chk(pwmReq == restPattern(on), "R2 rest levels after config", pwmReq, restPattern(on));

    enable = 1'b1;
    step();
    chk(!drvEn, "R4 drvEn low in mid cycle", drvEn, 0);
    chk(pwmReq == restPattern(on), "R4 all mid before drvEn", pwmReq, restPattern(on));
    step();
    chk(drvEn, "R4 drvEn after mid cycle", drvEn, 1);

    for (int k = 0; k < 5; k++) begin
      pwmPulse = NPH'($urandom);
      step();
      chk(dacCode == 0 && !ssDone, "R5 no ramp while not ready", {ssDone, dacCode}, 0);
      chk(pwmReq == restPattern(on), "R7 pulses ignored before ramp", pwmReq, restPattern(on));
    end
    pwmPulse = '0;

    drvReady = 1'b1;
    n = 0;
    while (!ssDone && n <= expGap + 10) begin
      step();
      n++;
      if (boot > 0 && n == per)
        chk(dacCode == 0, "R6 dac before first step", dacCode, 0);
      if (boot > 0 && n == per + 1)
        chk(dacCode == 1, "R6 dac after first step", dacCode, 1);
    end
    chk(n == expGap, "R6 ramp duration", n, expGap);
    chk(dacCode == boot, "R9 final dac equals captured boot", dacCode, boot);
    if (boot == 0)
      chk(pwmReq == restPattern(on) && dacCode == 0, "R10 zero target stays mid", pwmReq, restPattern(on));

    act = '0;
    for (int k = 0; k < 8; k++) begin
      pul = NPH'($urandom);
      pwmPulse = pul;
      step();
      act = act | (pul & on);
      chk(pwmReq == livePattern(on, act, pul), "R7 R3 phase levels follow pulses",
          pwmReq, livePattern(on, act, pul));
    end

    enable = 1'b0;
    step();
    chk(pwmReq == restPattern(on), "R8 mid on disable", pwmReq, restPattern(on));
    chk(!drvEn && !ssDone && dacCode == 0, "R8 outputs cleared on disable",
        {drvEn, ssDone, dacCode}, 0);
    pwmPulse = '0;
    drvReady = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    // Directed corner cases
    run_trial(8'd0,  1'b0, 6'b000000);       // R10 zero target
    run_trial(8'd5,  1'b1, 6'b111000);       // R3 rail 1 fully absent
    run_trial(8'd7,  1'b0, 6'b000111);       // R2 phase 0 flag ignored
    run_trial(8'd1,  1'b1, 6'b111111);       // R2 R3 only phase 0 left
    for (int t = 0; t < 6; t++)
      run_trial(8'($urandom_range(0, 40)), 1'($urandom), NPH'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule